// File: doc/BRIEF.md
# Configuration Mode Unlock Sequencer

This block sits on an I/O write stream and decides when a peripheral controller may enter its configuration mode. Every write carries an address and a data byte. Unlocking happens in two stages. In the first stage, four bytes are written to a fixed port at address 0x279. The last two of those bytes pick one of three base addresses. In the second stage, a fixed 32-byte key must arrive in order at the chosen base. Only after the final key byte does the block raise its configuration flag. The flag stays up until the register logic sends an exit request.

Writes enter on a valid/ready interface. The sequencer never applies back-pressure: `wr_ready` is always high after reset. A write is accepted on any rising clock edge where `wr_valid` is high. Outputs change on the edge that accepts the deciding write, so they are visible one cycle after that write is presented.

The key is not stored in a table. An 8-bit shift register produces it, starting from 0x6A. Each next byte is the current byte shifted right by one place, with bit 0 XOR bit 1 moved into bit 7.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset, `cfg_mode` and `base_valid` are 0 and `base_addr` is 0.
- R2: The prefix stage compares only writes to address 0x279. Writes to any other address leave the prefix progress unchanged.
- R3: The prefix 0x86, 0x80, 0x55, 0x55 sets `base_valid` and makes `base_addr` 0x3F0 on the edge that accepts the fourth byte.
- R4: The prefix 0x86, 0x80, 0x55, 0xAA selects 0x3BD, and 0x86, 0x80, 0xAA, 0x55 selects 0x370. A fourth byte 0xAA after a third byte 0xAA is a wrong byte.
- R5: Once a base is selected, the 32 key bytes (0x6A, 0xB5, 0xDA, ... produced by the shift rule above) must be written in order to that base. `cfg_mode` rises on the edge that accepts the 32nd byte, and not earlier.
- R6: A wrong byte written to the selected base during the key stage returns the block to the locked state. Both `base_valid` and `cfg_mode` are then 0, and the entry must start again from the first prefix byte.
- R7: A wrong prefix byte restarts the prefix. If that wrong byte is 0x86, it counts as the first prefix byte.
- R8: During the key stage, writes to addresses other than the selected base (including 0x279) neither advance nor break the key match.
- R9: `exit_req` clears `cfg_mode`, `base_valid` and any partial progress on the next edge, and it takes priority over a write in the same cycle.
- R10: `wr_ready` is always 1 after reset, and a cycle with `wr_valid` low changes no state, whatever values `wr_addr` and `wr_data` carry.
- R11: In configuration mode, writes of any kind leave `cfg_mode` set and `base_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | An I/O write is presented |
| wr_ready | output | 1 | Write accepted (always 1 after reset) |
| wr_addr | input | 16 | I/O address of the write |
| wr_data | input | 8 | Data byte of the write |
| exit_req | input | 1 | Leave configuration mode and clear all progress |
| cfg_mode | output | 1 | Configuration mode is active |
| base_valid | output | 1 | A base address has been selected |
| base_addr | output | 16 | Selected base address, 0 when none |

## Verification
The bound checker watches these rules on every cycle:
- `cfg_mode` only appears together with a legal base address.
- A base is only selected by a write to the prefix port.
- The flag only rises on a write to the selected base.
- An exit request clears everything.
- Idle cycles leave the outputs unchanged.
- Configuration mode holds for as long as no exit request arrives.

Some behaviours depend on the exact byte history, and only the bench's scenarios can show them:
- whether the right key byte was needed at each of the 32 positions;
- the 0x86 restart rule;
- the rejected 0xAA, 0xAA prefix;
- that noise writes leave the key position where it was.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
  localparam int IO_AW = 16;
  localparam int IO_DW = 8;

  localparam logic [IO_AW-1:0] PFX_PORT_DEF = 16'h0279;
  localparam logic [IO_AW-1:0] BASE_LL_DEF  = 16'h03F0;
  localparam logic [IO_AW-1:0] BASE_LH_DEF  = 16'h03BD;
  localparam logic [IO_AW-1:0] BASE_HL_DEF  = 16'h0370;

  localparam logic [IO_DW-1:0] PFX_B0  = 8'h86;
  localparam logic [IO_DW-1:0] PFX_B1  = 8'h80;
  localparam logic [IO_DW-1:0] LANE_LO = 8'h55;
  localparam logic [IO_DW-1:0] LANE_HI = 8'hAA;

  localparam logic [IO_DW-1:0] KEY_SEED_DEF = 8'h6A;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY    = 2'd1,
    ST_OPEN   = 2'd2
  } unlock_st_e;

  typedef enum logic [1:0] {
    SEL_LL = 2'd0,
    SEL_LH = 2'd1,
    SEL_HL = 2'd2
  } base_sel_e;

  function automatic logic [IO_DW-1:0] key_step(input logic [IO_DW-1:0] cur);
    return {cur[0] ^ cur[1], cur[IO_DW-1:1]};
  endfunction
endpackage

// File: rtl/cfg_prefix_match.sv
module cfg_prefix_match
  import cfg_unlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [IO_DW-1:0] data,
  output logic             done,
  output base_sel_e        sel
);
  localparam int PFX_LEN = 4;
  localparam int IDX_W   = $clog2(PFX_LEN);

  logic [IDX_W-1:0] idx_q;
  logic             lane_hi_q;
  logic             hit;
  logic             last;

  assign last = (idx_q == IDX_W'(PFX_LEN - 1));

  always_comb begin
    hit = 1'b0;
    unique case (idx_q)
      2'd0:    hit = (data == PFX_B0);
      2'd1:    hit = (data == PFX_B1);
      2'd2:    hit = (data == LANE_LO) || (data == LANE_HI);
      default: hit = (data == LANE_LO) || (!lane_hi_q && data == LANE_HI);
    endcase
  end

  always_comb begin
    if (lane_hi_q)            sel = SEL_HL;
    else if (data == LANE_HI) sel = SEL_LH;
    else                      sel = SEL_LL;
  end

  assign done = step && hit && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      lane_hi_q <= 1'b0;
    end else if (clr) begin
      idx_q     <= '0;
      lane_hi_q <= 1'b0;
    end else if (step) begin
      if (hit && last) begin
        idx_q     <= '0;
        lane_hi_q <= 1'b0;
      end else if (hit) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IDX_W'(2)) lane_hi_q <= (data == LANE_HI);
      end else begin
        idx_q     <= (data == PFX_B0) ? IDX_W'(1) : '0;
        lane_hi_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_unlock_pkg::*;
#(
  parameter int               KEY_LEN  = 32,
  parameter logic [IO_DW-1:0] KEY_SEED = KEY_SEED_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [IO_DW-1:0] data,
  output logic             ok,
  output logic             last
);
  localparam int CNT_W = $clog2(KEY_LEN + 1);

  logic [IO_DW-1:0] lfsr_q;
  logic [CNT_W-1:0] cnt_q;

  assign ok   = (data == lfsr_q);
  assign last = (cnt_q == CNT_W'(KEY_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= KEY_SEED;
      cnt_q  <= '0;
    end else if (load) begin
      lfsr_q <= KEY_SEED;
      cnt_q  <= '0;
    end else if (step && ok) begin
      lfsr_q <= key_step(lfsr_q);
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfg_unlock_pkg::*;
#(
  parameter int               KEY_LEN  = 32,
  parameter logic [IO_DW-1:0] KEY_SEED = KEY_SEED_DEF,
  parameter logic [IO_AW-1:0] PFX_PORT = PFX_PORT_DEF,
  parameter logic [IO_AW-1:0] BASE_LL  = BASE_LL_DEF,
  parameter logic [IO_AW-1:0] BASE_LH  = BASE_LH_DEF,
  parameter logic [IO_AW-1:0] BASE_HL  = BASE_HL_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IO_AW-1:0] wr_addr,
  input  logic [IO_DW-1:0] wr_data,
  input  logic             exit_req,
  output logic             cfg_mode,
  output logic             base_valid,
  output logic [IO_AW-1:0] base_addr
);
  unlock_st_e       st_q;
  logic [IO_AW-1:0] base_q;
  logic             acc;
  logic             pfx_step;
  logic             pfx_done;
  base_sel_e        pfx_sel;
  logic             key_step_en;
  logic             key_ok;
  logic             key_last;
  logic [IO_AW-1:0] sel_addr;
  logic             ready_q;

  // Writes are always taken once out of reset; no stall path exists.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign wr_ready = ready_q;

  assign acc         = wr_valid && ready_q && !exit_req;
  assign pfx_step    = acc && (st_q == ST_LOCKED) && (wr_addr == PFX_PORT);
  assign key_step_en = acc && (st_q == ST_KEY) && (wr_addr == base_q);

  always_comb begin
    unique case (pfx_sel)
      SEL_LH:  sel_addr = BASE_LH;
      SEL_HL:  sel_addr = BASE_HL;
      default: sel_addr = BASE_LL;
    endcase
  end

  cfg_prefix_match u_pfx (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (exit_req),
    .step (pfx_step),
    .data (wr_data),
    .done (pfx_done),
    .sel  (pfx_sel)
  );

  cfg_key_match #(
    .KEY_LEN (KEY_LEN),
    .KEY_SEED(KEY_SEED)
  ) u_key (
    .clk  (clk),
    .rst_n(rst_n),
    .load (pfx_done),
    .step (key_step_en),
    .data (wr_data),
    .ok   (key_ok),
    .last (key_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOCKED;
      base_q <= '0;
    end else if (exit_req) begin
      st_q   <= ST_LOCKED;
      base_q <= '0;
    end else begin
      unique case (st_q)
        ST_LOCKED: if (pfx_done) begin
          st_q   <= ST_KEY;
          base_q <= sel_addr;
        end
        ST_KEY: if (key_step_en) begin
          if (!key_ok) begin
            st_q   <= ST_LOCKED;
            base_q <= '0;
          end else if (key_last) begin
            st_q <= ST_OPEN;
          end
        end
        default: st_q <= ST_OPEN;
      endcase
    end
  end

  assign cfg_mode   = (st_q == ST_OPEN);
  assign base_valid = (st_q != ST_LOCKED);
  assign base_addr  = base_q;
endmodule

// File: rtl/cfg_unlock_seq_chk.sv
module cfg_unlock_seq_chk
  import cfg_unlock_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [IO_AW-1:0] wr_addr,
  input logic [IO_DW-1:0] wr_data,
  input logic             exit_req,
  input logic             cfg_mode,
  input logic             base_valid,
  input logic [IO_AW-1:0] base_addr
);
  p_mode_needs_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> base_valid);

  p_base_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid |-> (base_addr == BASE_LL_DEF || base_addr == BASE_LH_DEF ||
                    base_addr == BASE_HL_DEF));

  p_base_from_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(base_valid) |-> ($past(wr_valid) && $past(wr_addr) == PFX_PORT_DEF));

  p_open_on_base_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> ($past(wr_valid) && $past(wr_addr) == base_addr));

  p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> (!cfg_mode && !base_valid));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_valid) && !$past(exit_req)) |->
      ($stable(cfg_mode) && $stable(base_valid) && $stable(base_addr)));

  p_open_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && !exit_req) |=> (cfg_mode && $stable(base_addr)));
endmodule

bind cfg_unlock_seq cfg_unlock_seq_chk u_chk (.*);

// File: tb/cfg_unlock_seq_test.sv
module cfg_unlock_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        exit_req = 1'b0;
  logic        cfg_mode;
  logic        base_valid;
  logic [15:0] base_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_unlock_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .exit_req(exit_req),
    .cfg_mode(cfg_mode), .base_valid(base_valid), .base_addr(base_addr)
  );

  function automatic logic [7:0] key_byte(int i);
    logic [7:0] v = 8'h6A;
    for (int k = 0; k < i; k++) v = {v[0] ^ v[1], v[7:1]};
    return v;
  endfunction

  function automatic logic [15:0] base_of(logic [7:0] b2, logic [7:0] b3);
    if (b2 == 8'h55 && b3 == 8'h55) return 16'h03F0;
    if (b2 == 8'h55 && b3 == 8'hAA) return 16'h03BD;
    if (b2 == 8'hAA && b3 == 8'h55) return 16'h0370;
    return 16'h0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk);
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
  endtask

  task automatic prefix(logic [7:0] b2, logic [7:0] b3);
    wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
    wr(16'h0279, b2);    wr(16'h0279, b3);
  endtask

  task automatic keys(logic [15:0] base, int from, int upto);
    for (int i = from; i < upto; i++) wr(base, key_byte(i));
  endtask

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
          n_fail++; n_run++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 cfg_mode", cfg_mode, 0);
    check("R1 base_valid", base_valid, 0);
    check("R1 base_addr", base_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready", wr_ready, 1);

    // R3 full entry at 0x3F0, R5 flag only after the 32nd byte
    prefix(8'h55, 8'h55);
    check("R3 base_valid", base_valid, 1);
    check("R3 base_addr", base_addr, 16'h03F0);
    keys(16'h03F0, 0, 31);
    check("R5 not yet open", cfg_mode, 0);
    keys(16'h03F0, 31, 32);
    check("R5 open", cfg_mode, 1);
    // R11 writes in config mode
    wr(16'h03F0, 8'h00); wr(16'h0279, 8'h86);
    check("R11 stays open", cfg_mode, 1);
    check("R11 base held", base_addr, 16'h03F0);
    // R9 exit, then key alone does not reopen
    do_exit();
    check("R9 cleared mode", cfg_mode, 0);
    check("R9 cleared base", base_valid, 0);
    keys(16'h03F0, 0, 32);
    check("R9 key alone no entry", cfg_mode, 0);

    // R4 other bases and illegal combo
    prefix(8'h55, 8'hAA);
    check("R4 base 3BD", base_addr, 16'h03BD);
    keys(16'h03BD, 0, 32);
    check("R4 open 3BD", cfg_mode, 1);
    do_exit();
    prefix(8'hAA, 8'h55);
    check("R4 base 370", base_addr, 16'h0370);
    do_exit();
    prefix(8'hAA, 8'hAA);
    check("R4 AA AA rejected", base_valid, 0);

    // R7 restart on 0x86
    wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
    prefix(8'h55, 8'h55);
    check("R7 restart via 86", base_addr, 16'h03F0);
    do_exit();
    wr(16'h0279, 8'h86); wr(16'h0279, 8'h11);
    wr(16'h0279, 8'h80); wr(16'h0279, 8'h55); wr(16'h0279, 8'h55);
    check("R7 wrong byte restarts", base_valid, 0);

    // R2 other addresses ignored during prefix
    wr(16'h0279, 8'h86); wr(16'h03F0, 8'h00); wr(16'h0279, 8'h80);
    wr(16'h0100, 8'h86); wr(16'h0279, 8'h55); wr(16'h0279, 8'h55);
    check("R2 prefix completes", base_addr, 16'h03F0);

    // R6 wrong key byte
    keys(16'h03F0, 0, 10);
    wr(16'h03F0, key_byte(10) ^ 8'h01);
    check("R6 base cleared", base_valid, 0);
    keys(16'h03F0, 11, 32);
    check("R6 no entry", cfg_mode, 0);

    // R10 idle cycle carrying the right byte must not advance
    prefix(8'h55, 8'h55);
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 16'h03F0; wr_data = key_byte(0);
    @(negedge clk);
    keys(16'h03F0, 1, 32);
    check("R10 invalid cycle ignored", cfg_mode, 0);
    check("R10 mismatch relocks", base_valid, 0);

    // R9 exit wins over a same-cycle write
    prefix(8'h55, 8'h55);
    keys(16'h03F0, 0, 31);
    @(negedge clk);
    exit_req = 1'b1; wr_valid = 1'b1; wr_addr = 16'h03F0; wr_data = key_byte(31);
    @(negedge clk);
    exit_req = 1'b0; wr_valid = 1'b0;
    check("R9 exit priority", cfg_mode, 0);

    // R8 + random trials
    for (int t = 0; t < 40; t++) begin
      logic [7:0]  b2, b3;
      logic [15:0] exp_base;
      int          brk;
      b2 = ($urandom % 2) ? 8'hAA : 8'h55;
      b3 = ($urandom % 2) ? 8'hAA : 8'h55;
      exp_base = base_of(b2, b3);
      brk = (($urandom % 3) == 0) ? int'($urandom % 32) : 32;
      prefix(b2, b3);
      check("R4 random base", base_addr, exp_base);
      if (exp_base != 16'h0) begin
        for (int i = 0; i < 32; i++) begin
          if (($urandom % 4) == 0) begin
            logic [15:0] na;
            case ($urandom % 4)
              0: na = 16'h0279;
              1: na = 16'h0100;
              2: na = (exp_base == 16'h03F0) ? 16'h0370 : 16'h03F0;
              default: na = (exp_base == 16'h03BD) ? 16'h0370 : 16'h03BD;
            endcase
            wr(na, 8'($urandom));
          end
          wr(exp_base, (i == brk) ? (key_byte(i) ^ 8'h80) : key_byte(i));
          if (i == brk) break;
        end
        check("R8 noise vs key outcome", cfg_mode, (brk == 32) ? 1 : 0);
        check("R6 random base state", base_valid, (brk == 32) ? 1 : 0);
      end
      do_exit();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule